// File: doc/BRIEF.md
# Interrupt Source Routing Matrix

This block steers a small set of board interrupt sources onto a bank of destination lines. The sources are three management-controller requests, a hot-swap enumeration request, a mezzanine-slot request and a request from the third serial port. The destinations are six legacy ISA request lines, which are active-high, and two PCI interrupt pins, which are active-low. Every source owns one routing register. Each bit of that register connects the source to one destination. Any number of bits may be set, so one source can fan out to several lines, and several sources can share one line through an OR.

Software reaches the routing registers through an index/data port: it presents an index and data together with a write strobe, and the read data for the presented index is returned combinationally. A status register at its own index records every source that has been active since it was last cleared, whether or not that source is routed anywhere. Writing ones to the status index clears the matching bits.

Top module: `irq_route_matrix`

## Requirements
- R1: After reset every routing register and the status register read as zero, all ISA lines are low and both PCI pins are high.
- R2: A write to a source's index stores the data in that source's routing register, and a read at the same index returns it. The indices are 0x09, 0x0A and 0x0B for management sources 0 to 2, 0x11 for enumeration (source 3), 0x12 for the mezzanine slot (source 4) and 0x13 for the third serial port (source 5).
- R3: A write to an index that is neither a routing index nor the status index changes no register, and a read at such an index returns zero.
- R4: ISA output d (routing bits 0 to 5, one per line) is high exactly when at least one active source has bit d set in its routing register.
- R5: Routing bit 6 selects PCI pin A and bit 7 selects PCI pin D. pci_int_n_o[0] is pin A and pci_int_n_o[1] is pin D. Both pins are active-low and read high when no routed source is active.
- R6: A source whose register has several bits set drives every selected destination at the same time.
- R7: Status bit s (bit positions follow source numbers) is set on the clock edge after source s is seen high, whether or not the source is routed. It stays set after the source goes low.
- R8: A write to the status index 0x14 clears each status bit written as 1 and leaves bits written as 0 unchanged. A source that is still high at that edge keeps its bit set.
- R9: A read at index 0x14 returns the status bits in the low six bits, with zeros above them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| reg_wr_i | input | 1 | Write strobe for the index/data port |
| reg_idx_i | input | 8 | Register index |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the presented index (combinational) |
| src_i | input | 6 | Active-high interrupt sources, bit s is source s |
| isa_irq_o | output | 6 | Active-high ISA request lines |
| pci_int_n_o | output | 2 | Active-low PCI pins: bit 0 is pin A, bit 1 is pin D |

## Verification
The assertions check on every cycle that a register write lands in the addressed routing register, that writes to unmapped indices leave all routes unchanged, and how each status bit is set and cleared. They also check that the outputs stay idle whenever no source is active. Only the bench's scenarios can show the full routing function: OR-combining across sources, fan-out of one source to several lines, the opposite polarities of the ISA and PCI groups, and readback at each index. The bench checks these under directed cases and random writes and source patterns.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

   // Index of the routing register owned by source s.
   // Sources below n_low use consecutive indices from low_base; the rest from high_base.
   function automatic int unsigned route_index(input int unsigned s,
                                               input int unsigned n_low,
                                               input int unsigned low_base,
                                               input int unsigned high_base);
      if (s < n_low) return low_base + s;
      return high_base + (s - n_low);
   endfunction

   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_ROUTE = 2'd1,
      ACC_STAT  = 2'd2
   } acc_kind_t;

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
   import irq_route_pkg::*;
#(
   parameter int unsigned N_SRC     = 6,
   parameter int unsigned N_DST     = 8,
   parameter int unsigned IDX_W     = 8,
   parameter int unsigned N_LOW     = 3,
   parameter int unsigned LOW_BASE  = 9,
   parameter int unsigned HIGH_BASE = 17,
   parameter int unsigned STAT_IDX  = 20
) (
   input  logic                        clk_i,
   input  logic                        rst_i,
   input  logic                        wr_i,
   input  logic [IDX_W-1:0]            idx_i,
   input  logic [N_DST-1:0]            wdata_i,
   output logic [N_SRC-1:0][N_DST-1:0] route_o,
   output logic [N_SRC-1:0]            sel_o,
   output acc_kind_t                   kind_o,
   output logic [N_SRC-1:0]            stat_clr_o
);

   logic [N_SRC-1:0][N_DST-1:0] route_q;
   logic [N_SRC-1:0]            sel;

   for (genvar s = 0; s < N_SRC; s++) begin : g_dec
      localparam int unsigned IDX = route_index(s, N_LOW, LOW_BASE, HIGH_BASE);
      assign sel[s] = (idx_i == IDX_W'(IDX));
   end

   always_comb begin
      if (|sel)                             kind_o = ACC_ROUTE;
      else if (idx_i == IDX_W'(STAT_IDX))   kind_o = ACC_STAT;
      else                                  kind_o = ACC_NONE;
   end

   assign stat_clr_o = (wr_i && kind_o == ACC_STAT) ? wdata_i[N_SRC-1:0] : '0;
   assign sel_o      = sel;

   for (genvar s = 0; s < N_SRC; s++) begin : g_reg
      always_ff @(posedge clk_i) begin
         if (rst_i)                route_q[s] <= '0;
         else if (wr_i && sel[s])  route_q[s] <= wdata_i;
      end

      assert_route_write_R2 : assert property (@(posedge clk_i) disable iff (rst_i)
         (wr_i && idx_i == IDX_W'(route_index(s, N_LOW, LOW_BASE, HIGH_BASE)))
            |=> (route_o[s] == $past(wdata_i)));
   end

   assign route_o = route_q;

   assert_unmapped_hold_R3 : assert property (@(posedge clk_i) disable iff (rst_i)
      (wr_i && kind_o != ACC_ROUTE) |=> $stable(route_o));

endmodule

// File: rtl/irq_status_cap.sv
module irq_status_cap #(
   parameter int unsigned N_SRC = 6
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [N_SRC-1:0] src_i,
   input  logic [N_SRC-1:0] clr_i,
   output logic [N_SRC-1:0] stat_o
);

   logic [N_SRC-1:0] stat_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) stat_q <= '0;
      else       stat_q <= src_i | (stat_q & ~clr_i);
   end

   assign stat_o = stat_q;

   for (genvar s = 0; s < N_SRC; s++) begin : g_chk
      assert_status_set_R7 : assert property (@(posedge clk_i) disable iff (rst_i)
         src_i[s] |=> stat_o[s]);
      assert_status_sticky_R7 : assert property (@(posedge clk_i) disable iff (rst_i)
         (stat_o[s] && !clr_i[s]) |=> stat_o[s]);
      assert_status_clear_R8 : assert property (@(posedge clk_i) disable iff (rst_i)
         (clr_i[s] && !src_i[s]) |=> !stat_o[s]);
   end

endmodule

// File: rtl/irq_dest_combine.sv
module irq_dest_combine #(
   parameter int unsigned N_SRC   = 6,
   parameter int unsigned N_DST   = 8,
   parameter int unsigned N_ISA   = 6,
   parameter bit          PCI_LOW = 1'b1
) (
   input  logic [N_SRC-1:0]            src_i,
   input  logic [N_SRC-1:0][N_DST-1:0] route_i,
   output logic [N_DST-1:0]            line_o
);

   localparam int unsigned N_PCI = N_DST - N_ISA;

   for (genvar d = 0; d < N_DST; d++) begin : g_dst
      logic [N_SRC-1:0] col;
      for (genvar s = 0; s < N_SRC; s++) begin : g_col
         assign col[s] = route_i[s][d] & src_i[s];
      end
      if (d >= N_ISA && PCI_LOW) begin : g_low
         assign line_o[d] = ~(|col);
      end else begin : g_high
         assign line_o[d] = |col;
      end
   end

   if (N_PCI < 1) begin : g_bad
      $error("irq_dest_combine: no PCI destinations");
   end

endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix
   import irq_route_pkg::*;
#(
   parameter int unsigned N_LOW     = 3,
   parameter int unsigned N_HIGH    = 3,
   parameter int unsigned N_ISA     = 6,
   parameter int unsigned N_PCI     = 2,
   parameter int unsigned IDX_W     = 8,
   parameter int unsigned LOW_BASE  = 9,
   parameter int unsigned HIGH_BASE = 17,
   parameter int unsigned STAT_IDX  = 20,
   localparam int unsigned N_SRC    = N_LOW + N_HIGH,
   localparam int unsigned N_DST    = N_ISA + N_PCI
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             reg_wr_i,
   input  logic [IDX_W-1:0] reg_idx_i,
   input  logic [N_DST-1:0] reg_wdata_i,
   output logic [N_DST-1:0] reg_rdata_o,
   input  logic [N_SRC-1:0] src_i,
   output logic [N_ISA-1:0] isa_irq_o,
   output logic [N_PCI-1:0] pci_int_n_o
);

   if (N_SRC > N_DST) begin : g_chk_w
      $error("irq_route_matrix: status wider than data port");
   end
   if (STAT_IDX >= (1 << IDX_W) || HIGH_BASE + N_HIGH > (1 << IDX_W)) begin : g_chk_i
      $error("irq_route_matrix: index out of range");
   end
   if (LOW_BASE + N_LOW > HIGH_BASE) begin : g_chk_o
      $error("irq_route_matrix: index groups overlap");
   end

   logic [N_SRC-1:0][N_DST-1:0] route;
   logic [N_SRC-1:0]            sel;
   logic [N_SRC-1:0]            clr;
   logic [N_SRC-1:0]            stat;
   logic [N_DST-1:0]            lines;
   acc_kind_t                   kind;

   irq_route_regs #(
      .N_SRC(N_SRC), .N_DST(N_DST), .IDX_W(IDX_W), .N_LOW(N_LOW),
      .LOW_BASE(LOW_BASE), .HIGH_BASE(HIGH_BASE), .STAT_IDX(STAT_IDX)
   ) u_regs (
      .clk_i(clk_i), .rst_i(rst_i), .wr_i(reg_wr_i), .idx_i(reg_idx_i),
      .wdata_i(reg_wdata_i), .route_o(route), .sel_o(sel), .kind_o(kind),
      .stat_clr_o(clr)
   );

   irq_status_cap #(.N_SRC(N_SRC)) u_stat (
      .clk_i(clk_i), .rst_i(rst_i), .src_i(src_i), .clr_i(clr), .stat_o(stat)
   );

   irq_dest_combine #(
      .N_SRC(N_SRC), .N_DST(N_DST), .N_ISA(N_ISA), .PCI_LOW(1'b1)
   ) u_comb (
      .src_i(src_i), .route_i(route), .line_o(lines)
   );

   assign isa_irq_o   = lines[N_ISA-1:0];
   assign pci_int_n_o = lines[N_DST-1:N_ISA];

   always_comb begin
      reg_rdata_o = '0;
      case (kind)
         ACC_ROUTE: begin
            for (int s = 0; s < N_SRC; s++)
               if (sel[s]) reg_rdata_o = route[s];
         end
         ACC_STAT:  reg_rdata_o = N_DST'(stat);
         default:   reg_rdata_o = '0;
      endcase
   end

   assert_idle_outputs_R5 : assert property (@(posedge clk_i) disable iff (rst_i)
      (src_i == '0) |-> (isa_irq_o == '0 && pci_int_n_o == '1));

endmodule

// File: tb/tb_irq_route_matrix.sv
module tb_irq_route_matrix;

   logic       clk = 1'b0;
   logic       rst;
   logic       wr;
   logic [7:0] idx;
   logic [7:0] wdata;
   logic [7:0] rdata;
   logic [5:0] src;
   logic [5:0] isa;
   logic [1:0] pci_n;

   int unsigned total = 0;
   int unsigned bad   = 0;
   bit          done  = 1'b0;

   logic [7:0] route_m [6];
   logic [5:0] stat_m;

   always #4 clk = ~clk;

   irq_route_matrix dut (
      .clk_i(clk), .rst_i(rst), .reg_wr_i(wr), .reg_idx_i(idx),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata), .src_i(src),
      .isa_irq_o(isa), .pci_int_n_o(pci_n)
   );

   function automatic int src_of(input logic [7:0] i);
      case (i)
         8'h09: return 0;
         8'h0A: return 1;
         8'h0B: return 2;
         8'h11: return 3;
         8'h12: return 4;
         8'h13: return 5;
         default: return -1;
      endcase
   endfunction

   function automatic logic [7:0] idx_of(input int s);
      return (s < 3) ? 8'(8'h09 + s) : 8'(8'h11 + s - 3);
   endfunction

   function automatic logic [7:0] exp_lines();
      logic [7:0] acc = '0;
      for (int s = 0; s < 6; s++) if (src[s]) acc |= route_m[s];
      return acc;
   endfunction

   function automatic logic [7:0] exp_rdata();
      if (src_of(idx) >= 0) return route_m[src_of(idx)];
      if (idx == 8'h14)     return {2'b00, stat_m};
      return 8'h00;
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_outputs();
      logic [7:0] l = exp_lines();
      check("R4 isa lines", {2'b00, isa}, {2'b00, l[5:0]});
      check("R5 pci pins", {6'b0, pci_n}, {6'b0, ~l[7:6]});
      if (src_of(idx) >= 0)  check("R2 route readback", rdata, exp_rdata());
      else if (idx == 8'h14) check("R9 status readback", rdata, exp_rdata());
      else                   check("R3 unmapped read", rdata, exp_rdata());
   endtask

   task automatic step();
      logic [5:0] clr;
      #1 check_outputs();
      @(posedge clk);
      clr = '0;
      if (wr) begin
         if (src_of(idx) >= 0) route_m[src_of(idx)] = wdata;
         else if (idx == 8'h14) clr = wdata[5:0];
      end
      stat_m = src | (stat_m & ~clr);
      @(negedge clk);
   endtask

   task automatic drive(input logic w, input logic [7:0] i, input logic [7:0] d,
                        input logic [5:0] s);
      wr = w; idx = i; wdata = d; src = s;
      step();
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      rst = 1'b1; wr = 1'b0; idx = 8'h00; wdata = 8'h00; src = '0;
      for (int s = 0; s < 6; s++) route_m[s] = '0;
      stat_m = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;

      // R1: reset state
      #1;
      check("R1 isa idle", {2'b00, isa}, 8'h00);
      check("R1 pci idle", {6'b0, pci_n}, 8'h03);
      for (int s = 0; s < 6; s++) begin
         idx = idx_of(s); #1;
         check("R1 route zero", rdata, 8'h00);
      end
      idx = 8'h14; #1;
      check("R1 status zero", rdata, 8'h00);
      @(negedge clk);

      // R7: status captured although nothing is routed
      drive(1'b0, 8'h14, 8'h00, 6'b100001);
      drive(1'b0, 8'h14, 8'h00, 6'b000000);
      #1 check("R7 unrouted status sticky", rdata, 8'h21);
      check("R7 no output when unrouted", {2'b00, isa}, 8'h00);
      @(negedge clk);

      // R8: partial clear, set wins over clear
      drive(1'b1, 8'h14, 8'h01, 6'b000000);
      #1 check("R8 partial clear", rdata, 8'h20);
      @(negedge clk);
      drive(1'b1, 8'h14, 8'h3F, 6'b000010);
      #1 check("R8 set wins over clear", rdata, 8'h02);
      @(negedge clk);
      drive(1'b1, 8'h14, 8'h3F, 6'b000000);

      // R2: program each routing register
      for (int s = 0; s < 6; s++) drive(1'b1, idx_of(s), 8'(8'h10 + s * 8'h21), 6'b0);

      // R6: fan-out of one source to ISA and both PCI pins
      drive(1'b1, 8'h12, 8'b1100_1001, 6'b0);
      drive(1'b0, 8'h12, 8'h00, 6'b010000);
      src = 6'b010000; #1;
      check("R6 fan-out isa", {2'b00, isa}, 8'b0000_1001);
      check("R6 fan-out pci", {6'b0, pci_n}, 8'h00);
      @(negedge clk);

      // R3: writes to unmapped indices leave every route untouched
      drive(1'b1, 8'h10, 8'hFF, 6'b0);
      drive(1'b1, 8'h0C, 8'hFF, 6'b0);
      drive(1'b1, 8'h08, 8'hFF, 6'b0);
      for (int s = 0; s < 6; s++) begin
         idx = idx_of(s); wr = 1'b0; #1;
         check("R3 route kept after unmapped write", rdata, route_m[s]);
      end
      @(negedge clk);

      // random mix
      for (int n = 0; n < 3000; n++) begin
         logic [7:0] ri;
         int         k = $urandom_range(0, 9);
         if (k < 6)       ri = idx_of(k);
         else if (k == 6) ri = 8'h14;
         else             ri = 8'($urandom_range(0, 255));
         drive($urandom_range(0, 3) == 0, ri, 8'($urandom), 6'($urandom & $urandom));
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule